// File: doc/BRIEF.md
# Virtual Interrupt Preemption and Line Signalling

This block sits after the virtual interrupt arbiter in a processor's interrupt interface. The arbiter picks one pending virtual interrupt and hands over whether a candidate exists, its priority and its group. The block then decides whether that candidate may be signalled to the processor. It checks the hypervisor interface enable, the virtual priority mask and the priority of the interrupt that is already running. If the candidate may be signalled, it raises the interrupt line that matches the candidate's group.

The block also drives the maintenance interrupt from a condition vector that other logic computes. Two strobes start an update. A full refresh recomputes all three outputs. An exception-level-change strobe recomputes only the two virtual lines and leaves the maintenance output as it was. Between strobes every output holds its last value. All outputs are registered levels, so an output changes one clock after the strobe that updates it.

All pins are plain control and status levels. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `vsig_signal_top`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, virq_o, vfiq_o and maint_o are all 0.
- R2: If if_en_i is 0 at an update strobe, virq_o and vfiq_o are 0 on the next cycle. A refresh with if_en_i at 0 also gives maint_o = 0.
- R3: A candidate whose sel_prio_i is greater than or equal to vpmr_i is masked. After the update, neither line is raised.
- R4: If run_prio_i is all ones (nothing active), an enabled, unmasked, valid candidate is signalled whatever its priority.
- R5: Otherwise the candidate is signalled only if (sel_prio_i AND mask) < (run_prio_i AND mask), with strict less-than. The mask is gmask0_i for group 0 and gmask1_i for group 1. Bits outside the mask (subpriority) do not count.
- R6: sel_grp_i = 0 (group 0) raises vfiq_o, and sel_grp_i = 1 (group 1) raises virq_o. The two lines are never high together.
- R7: On a refresh, maint_o becomes 1 exactly when if_en_i is 1 and maint_cond_i is nonzero.
- R8: A lone el_change_i strobe re-evaluates virq_o and vfiq_o from the current inputs and leaves maint_o unchanged.
- R9: In a cycle with neither strobe, all three outputs keep their values, even if the inputs change.
- R10: If sel_valid_i is 0 at an update, both lines are 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_i | input | 1 | Strobe: recompute all outputs |
| el_change_i | input | 1 | Strobe: exception level changed, recompute virq_o and vfiq_o only |
| sel_valid_i | input | 1 | The arbiter has a candidate |
| sel_prio_i | input | PRIO_W | Candidate priority (lower value means more urgent) |
| sel_grp_i | input | 1 | Candidate group: 0 = group 0, 1 = group 1 |
| vpmr_i | input | PRIO_W | Virtual priority mask |
| run_prio_i | input | PRIO_W | Running priority; all ones means nothing is active |
| gmask0_i | input | PRIO_W | Group-priority mask for group 0 (upper bits set) |
| gmask1_i | input | PRIO_W | Group-priority mask for group 1 (upper bits set) |
| if_en_i | input | 1 | Hypervisor virtual interface enable |
| maint_cond_i | input | MAINT_W | Maintenance conditions; any set bit requests the interrupt |
| virq_o | output | 1 | Virtual IRQ level |
| vfiq_o | output | 1 | Virtual FIQ level |
| maint_o | output | 1 | Maintenance interrupt level |

## Verification
The bench builds the block with PRIO_W = 8 and MAINT_W = 4. An 8-bit priority lets every binary-point mask from 0xFE down to 0x80 appear, and it lets the all-ones idle value be reached in both the running priority and the mask. The narrow condition vector makes a zero maintenance condition common under random stimulus, so both maintenance outcomes appear often. Random priorities and masks exercise the strict grouped comparison. Directed cases pin down equality at the mask, equal group priority with different subpriority, and an exception-level strobe that arrives while the maintenance condition has changed.

// File: rtl/vsig_pkg.sv
package vsig_pkg;
  typedef enum logic {
    VSIG_GRP0 = 1'b0,
    VSIG_GRP1 = 1'b1
  } vsig_grp_e;

  typedef struct packed {
    logic irq;
    logic fiq;
  } vsig_lines_t;
endpackage

// File: rtl/vsig_prio_gate.sv
module vsig_prio_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              sel_valid_i,
  input  logic [PRIO_W-1:0] sel_prio_i,
  input  logic              sel_grp_i,
  input  logic [PRIO_W-1:0] vpmr_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic [PRIO_W-1:0] gmask0_i,
  input  logic [PRIO_W-1:0] gmask1_i,
  input  logic              if_en_i,
  output logic              may_preempt_o
);
  localparam logic [PRIO_W-1:0] IdlePrio = {PRIO_W{1'b1}};

  logic [PRIO_W-1:0] grp_mask;
  logic              unmasked;
  logic              nothing_running;
  logic              beats_running;

  // Pick the mask of the candidate's own group.
  always_comb begin
    grp_mask = (sel_grp_i == vsig_pkg::VSIG_GRP1) ? gmask1_i : gmask0_i;
  end

  assign unmasked        = sel_prio_i < vpmr_i;
  assign nothing_running = run_prio_i == IdlePrio;
  // Only group-priority bits take part; strict less-than.
  assign beats_running   = (sel_prio_i & grp_mask) < (run_prio_i & grp_mask);

  assign may_preempt_o = if_en_i && sel_valid_i && unmasked &&
                         (nothing_running || beats_running);
endmodule

// File: rtl/vsig_line_route.sv
module vsig_line_route (
  input  logic                  preempt_i,
  input  logic                  grp_i,
  output vsig_pkg::vsig_lines_t lines_o
);
  always_comb begin
    lines_o.irq = preempt_i && (grp_i == vsig_pkg::VSIG_GRP1);
    lines_o.fiq = preempt_i && (grp_i == vsig_pkg::VSIG_GRP0);
  end
endmodule

// File: rtl/vsig_out_regs.sv
module vsig_out_regs (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  refresh_i,
  input  logic                  el_change_i,
  input  vsig_pkg::vsig_lines_t lines_nxt_i,
  input  logic                  maint_nxt_i,
  output vsig_pkg::vsig_lines_t lines_q_o,
  output logic                  maint_q_o
);
  logic upd_lines;
  assign upd_lines = refresh_i || el_change_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q_o <= '0;
    end else if (upd_lines) begin
      lines_q_o <= lines_nxt_i;
    end
  end

  // The maintenance level follows only a full refresh.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maint_q_o <= 1'b0;
    end else if (refresh_i) begin
      maint_q_o <= maint_nxt_i;
    end
  end
endmodule

// File: rtl/vsig_signal_top.sv
module vsig_signal_top #(
  parameter int PRIO_W  = 8,
  parameter int MAINT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               refresh_i,
  input  logic               el_change_i,
  input  logic               sel_valid_i,
  input  logic [PRIO_W-1:0]  sel_prio_i,
  input  logic               sel_grp_i,
  input  logic [PRIO_W-1:0]  vpmr_i,
  input  logic [PRIO_W-1:0]  run_prio_i,
  input  logic [PRIO_W-1:0]  gmask0_i,
  input  logic [PRIO_W-1:0]  gmask1_i,
  input  logic               if_en_i,
  input  logic [MAINT_W-1:0] maint_cond_i,
  output logic               virq_o,
  output logic               vfiq_o,
  output logic               maint_o
);
  logic                  preempt;
  logic                  maint_nxt;
  vsig_pkg::vsig_lines_t lines_nxt;
  vsig_pkg::vsig_lines_t lines_q;

  vsig_prio_gate #(.PRIO_W(PRIO_W)) u_gate (
    .sel_valid_i  (sel_valid_i),
    .sel_prio_i   (sel_prio_i),
    .sel_grp_i    (sel_grp_i),
    .vpmr_i       (vpmr_i),
    .run_prio_i   (run_prio_i),
    .gmask0_i     (gmask0_i),
    .gmask1_i     (gmask1_i),
    .if_en_i      (if_en_i),
    .may_preempt_o(preempt)
  );

  vsig_line_route u_route (
    .preempt_i(preempt),
    .grp_i    (sel_grp_i),
    .lines_o  (lines_nxt)
  );

  assign maint_nxt = if_en_i && (|maint_cond_i);

  vsig_out_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .refresh_i  (refresh_i),
    .el_change_i(el_change_i),
    .lines_nxt_i(lines_nxt),
    .maint_nxt_i(maint_nxt),
    .lines_q_o  (lines_q),
    .maint_q_o  (maint_o)
  );

  assign virq_o = lines_q.irq;
  assign vfiq_o = lines_q.fiq;

  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(virq_o && vfiq_o)); // R6
  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && !if_en_i) |=> (!virq_o && !vfiq_o && !maint_o)); // R2
  AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((refresh_i || el_change_i) && (sel_prio_i >= vpmr_i)) |=> (!virq_o && !vfiq_o)); // R3
  AST_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((refresh_i || el_change_i) && !sel_valid_i) |=> (!virq_o && !vfiq_o)); // R10
  AST_EL_MAINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_change_i && !refresh_i) |=> $stable(maint_o)); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!el_change_i && !refresh_i) |=> ($stable(virq_o) && $stable(vfiq_o) && $stable(maint_o))); // R9
endmodule

// File: tb/vsig_signal_top_tb_top.sv
module vsig_signal_top_tb_top;
  localparam int PW = 8;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          refresh, el_change, sel_valid, sel_grp, if_en;
  logic [PW-1:0] sel_prio, vpmr, run_prio, gmask0, gmask1;
  logic [MW-1:0] maint_cond;
  logic          virq, vfiq, maint;

  int n_tests = 0;
  int n_fail  = 0;
  logic e_irq = 1'b0, e_fiq = 1'b0, e_maint = 1'b0;

  always #10 clk = ~clk;

  vsig_signal_top #(.PRIO_W(PW), .MAINT_W(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .refresh_i(refresh), .el_change_i(el_change),
    .sel_valid_i(sel_valid), .sel_prio_i(sel_prio), .sel_grp_i(sel_grp),
    .vpmr_i(vpmr), .run_prio_i(run_prio), .gmask0_i(gmask0), .gmask1_i(gmask1),
    .if_en_i(if_en), .maint_cond_i(maint_cond),
    .virq_o(virq), .vfiq_o(vfiq), .maint_o(maint)
  );

  function automatic logic model_pre();
    logic [PW-1:0] m;
    m = sel_grp ? gmask1 : gmask0;
    if (!if_en || !sel_valid) return 1'b0;
    if (sel_prio >= vpmr) return 1'b0;
    if (run_prio == 8'hFF) return 1'b1;
    return (sel_prio & m) < (run_prio & m);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step(logic rf, logic el, string req);
    logic p;
    refresh = rf;
    el_change = el;
    p = model_pre();
    if (rf || el) begin
      e_irq = p && sel_grp;
      e_fiq = p && !sel_grp;
    end
    if (rf) e_maint = if_en && (|maint_cond);
    @(posedge clk);
    @(negedge clk);
    refresh = 1'b0;
    el_change = 1'b0;
    check(req, virq, e_irq, "virq");
    check(req, vfiq, e_fiq, "vfiq");
    check(req, maint, e_maint, "maint");
  endtask

  task automatic set_in(logic v, logic [PW-1:0] p, logic g, logic [PW-1:0] pm,
                        logic [PW-1:0] rp, logic [PW-1:0] m0, logic [PW-1:0] m1,
                        logic en, logic [MW-1:0] mc);
    sel_valid = v; sel_prio = p; sel_grp = g; vpmr = pm; run_prio = rp;
    gmask0 = m0; gmask1 = m1; if_en = en; maint_cond = mc;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; refresh = 1'b0; el_change = 1'b0;
    set_in(1'b1, 8'h10, 1'b1, 8'hF0, 8'hFF, 8'hF0, 8'hF0, 1'b1, 4'h1);
    repeat (3) @(negedge clk);
    check("R1", virq, 1'b0, "virq in reset");
    check("R1", vfiq, 1'b0, "vfiq in reset");
    check("R1", maint, 1'b0, "maint in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", virq | vfiq | maint, 1'b0, "outputs after reset");

    // R4 idle running priority, group 1 -> irq
    set_in(1'b1, 8'h80, 1'b1, 8'hF0, 8'hFF, 8'hF8, 8'hF8, 1'b1, 4'h0);
    step(1'b1, 1'b0, "R4");
    // R6 group 0 -> fiq, R7 maint on
    set_in(1'b1, 8'h80, 1'b0, 8'hF0, 8'hFF, 8'hF8, 8'hF8, 1'b1, 4'h4);
    step(1'b1, 1'b0, "R6");
    // R3 priority equal to mask
    set_in(1'b1, 8'hA0, 1'b0, 8'hA0, 8'hFF, 8'hF0, 8'hF0, 1'b1, 4'h4);
    step(1'b1, 1'b0, "R3");
    // R5 same group priority, lower subpriority -> no preempt
    set_in(1'b1, 8'h41, 1'b1, 8'hF0, 8'h4E, 8'hFF, 8'hF0, 1'b1, 4'h4);
    step(1'b1, 1'b0, "R5");
    // R5 group 0 uses its own finer mask -> preempts
    set_in(1'b1, 8'h41, 1'b0, 8'hF0, 8'h4E, 8'hFE, 8'hF0, 1'b1, 4'h4);
    step(1'b1, 1'b0, "R5");
    // R8 el change while maint condition vanished: maint held
    set_in(1'b1, 8'h20, 1'b1, 8'hF0, 8'hFF, 8'hF0, 8'hF0, 1'b1, 4'h0);
    step(1'b0, 1'b1, "R8");
    // R9 no strobe, inputs change
    set_in(1'b0, 8'hFF, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 4'hF);
    step(1'b0, 1'b0, "R9");
    // R10 no candidate
    set_in(1'b0, 8'h10, 1'b1, 8'hF0, 8'hFF, 8'hF0, 8'hF0, 1'b1, 4'h2);
    step(1'b1, 1'b0, "R10");
    // R2 interface disabled
    set_in(1'b1, 8'h10, 1'b1, 8'hF0, 8'hFF, 8'hF0, 8'hF0, 1'b0, 4'h2);
    step(1'b1, 1'b0, "R2");
    // R7 maint with enable and zero condition
    set_in(1'b1, 8'h10, 1'b0, 8'hF0, 8'hFF, 8'hF0, 8'hF0, 1'b1, 4'h0);
    step(1'b1, 1'b0, "R7");

    for (int i = 0; i < 400; i++) begin
      int b0 = $urandom_range(6, 0);
      int b1 = $urandom_range(6, 0);
      logic [PW-1:0] rp = ($urandom_range(3, 0) == 0) ? 8'hFF : PW'($urandom);
      set_in(($urandom_range(7, 0) != 0), PW'($urandom), 1'($urandom), PW'($urandom),
             rp, 8'hFE << b0, 8'hFE << b1, ($urandom_range(5, 0) != 0), MW'($urandom));
      case ($urandom_range(3, 0))
        0: step(1'b1, 1'b0, "R5 random refresh");
        1: step(1'b0, 1'b1, "R8 random el change");
        2: step(1'b1, 1'b1, "R6 random both");
        default: step(1'b0, 1'b0, "R9 random hold");
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule